// File: doc/BRIEF.md
# Exhaustive Four-Bit Pattern Source

This block produces every four-bit pattern in turn, for use as the stimulus side of an exhaustive self-test. It is a four-bit shift register. On each enabled clock it shifts left, and the new low bit comes from feedback on bits 3 and 0. With pure XOR feedback it cycles through the fifteen non-zero codes. With the extended feedback it also passes through the all-zero code once per lap, which gives a sixteen-state cycle.

A mode input chooses between the two sequences on every step. Reset places the register at 1000, and the lap restarts there. A start strobe marks each cycle in which the register holds 1000 and a step is about to happen, so a response compactor downstream can frame its signature windows. If the register is ever at 0000 while in the fifteen-state mode, it is forced back to 1000 so that it cannot lock up.

Top module: `walk16_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads the state 1000 (binary, bit 3 on the left), whatever `en` and `mode_full` are.
- R2: With `rst` low and `en` low, the state keeps its value across the clock edge.
- R3: In linear mode (`mode_full` = 0) with `en` high and a non-zero state, the next state is the current state shifted left one place, with the XOR of current bits 3 and 0 entering bit 0.
- R4: In linear mode, starting from reset, the state follows 1000, 0001, 0011, 0111, 1111, 1110, 1101, 1010, 0101, 1011, 0110, 1100, 1001, 0010, 0100 and then returns to 1000. It never shows 0000.
- R5: In full mode (`mode_full` = 1) the feedback bit is inverted whenever state bits 2:0 are all zero. This gives the steps 1000 → 0000 → 0001, and all 16 codes appear once in 16 enabled steps from 1000.
- R6: In linear mode with `en` high, a state of 0000 steps to 1000.
- R7: `start` is high exactly when `rst` is low, `en` is high and the state is 1000. It is combinational, so it lasts one cycle per lap.
- R8: `mode_full` is sampled at every step, so a change takes effect on the very next step, including the step out of 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable |
| mode_full | input | 1 | 1 = sixteen-state cycle, 0 = fifteen-state linear cycle |
| state | output | 4 | Current pattern |
| start | output | 1 | High while the register is at 1000 and a step is enabled |

## Verification
Two events can occur in the same cycle. The start strobe flags the 1000 state, and the mode decision made at that very step determines whether 0000 or 0001 comes next. The bench holds the register at 1000 with the strobe high and changes the mode just before the edge. It then checks that the successor follows the newly applied mode. In a second case, reset and enable are driven high together, and the bench checks that reset wins and that the strobe stays low.

// File: rtl/walk16_pkg.sv
package walk16_pkg;
  localparam int unsigned STATE_W = 4;
  localparam logic [STATE_W-1:0] SEED = 4'b1000;
  localparam logic [STATE_W-1:0] TAP_MASK = 4'b1001;

  function automatic logic tap_xor(input logic [STATE_W-1:0] s);
    return ^(s & TAP_MASK);
  endfunction

  function automatic logic low_clear(input logic [STATE_W-1:0] s);
    return (s[STATE_W-2:0] == '0);
  endfunction

  function automatic logic [STATE_W-1:0] shift_in(input logic [STATE_W-1:0] s,
                                                  input logic b);
    return {s[STATE_W-2:0], b};
  endfunction
endpackage

// File: rtl/walk16_next.sv
module walk16_next
  import walk16_pkg::*;
(
  input  logic [STATE_W-1:0] cur,
  input  logic               mode_full,
  output logic [STATE_W-1:0] nxt,
  output logic               splice,
  output logic               recover
);
  logic lin_fb;
  logic fb;

  always_comb begin
    lin_fb  = tap_xor(cur);
    splice  = mode_full && low_clear(cur);
    recover = !mode_full && (cur == '0);
    fb      = lin_fb ^ splice;
    if (recover) nxt = SEED;
    else         nxt = shift_in(cur, fb);
  end
endmodule

// File: rtl/walk16_reg.sv
module walk16_reg
  import walk16_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [STATE_W-1:0] nxt,
  output logic [STATE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= SEED;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/walk16_mark.sv
module walk16_mark
  import walk16_pkg::*;
(
  input  logic               rst,
  input  logic               en,
  input  logic [STATE_W-1:0] q,
  output logic               start
);
  assign start = !rst && en && (q == SEED);
endmodule

// File: rtl/walk16_gen.sv
module walk16_gen
  import walk16_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   mode_full,
  output logic [STATE_W-1:0]     state,
  output logic                   start
);
  logic [STATE_W-1:0] nxt_w;
  logic               splice_w;
  logic               recover_w;
  logic               step_w;

  assign step_w = en && !rst;

  walk16_next u_next (
    .cur       (state),
    .mode_full (mode_full),
    .nxt       (nxt_w),
    .splice    (splice_w),
    .recover   (recover_w)
  );

  walk16_reg u_reg (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .nxt (nxt_w),
    .q   (state)
  );

  walk16_mark u_mark (
    .rst   (rst),
    .en    (en),
    .q     (state),
    .start (start)
  );
endmodule

// File: rtl/walk16_chk.sv
module walk16_chk
  import walk16_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic               mode_full,
  input logic [STATE_W-1:0] state,
  input logic               start,
  input logic               splice,
  input logic               recover,
  input logic               step
);
  a_r1_seed_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> state == SEED);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state));

  a_r3_linear_shift: assert property (@(posedge clk) disable iff (rst)
    (step && !mode_full && state != '0) |=>
      state[STATE_W-1:1] == $past(state[STATE_W-2:0]) &&
      state[0] == ($past(state[3]) ^ $past(state[0])));

  a_r4_no_zero_linear: assert property (@(posedge clk) disable iff (rst)
    (step && !mode_full) |=> state != '0);

  a_r5_enter_zero: assert property (@(posedge clk) disable iff (rst)
    (step && mode_full && state == SEED) |=> state == '0);

  a_r5_leave_zero: assert property (@(posedge clk) disable iff (rst)
    (step && mode_full && state == '0) |=> state == 4'b0001);

  a_r5_splice_scope: assert property (@(posedge clk) disable iff (rst)
    splice |-> (state == SEED || state == '0));

  a_r6_unlock: assert property (@(posedge clk) disable iff (rst)
    (step && recover) |=> state == SEED);

  a_r7_start_shape: assert property (@(posedge clk) disable iff (rst)
    start |-> (en && state == SEED));
endmodule

bind walk16_gen walk16_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .mode_full (mode_full),
  .state     (state),
  .start     (start),
  .splice    (splice_w),
  .recover   (recover_w),
  .step      (step_w)
);

// File: tb/walk16_gen_bench.sv
module walk16_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic       mode_full = 1'b0;
  logic [3:0] state;
  logic       start;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [3:0] LIN_SEQ [15] = '{4'h8, 4'h1, 4'h3, 4'h7, 4'hF,
    4'hE, 4'hD, 4'hA, 4'h5, 4'hB, 4'h6, 4'hC, 4'h9, 4'h2, 4'h4};

  always #2 clk = ~clk;

  walk16_gen u_walk16_gen (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .mode_full (mode_full),
    .state     (state),
    .start     (start)
  );

  function automatic logic [3:0] model(input logic [3:0] s, input logic m);
    if (m && s == 4'd8) return 4'd0;
    if (m && s == 4'd0) return 4'd1;
    if (!m && s == 4'd0) return 4'd8;
    return ((s * 2) % 16) | {3'b0, s[3] ^ s[0]};
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // drive at falling edge, sample 1 ns after the rising edge
  task automatic tick(input logic r, input logic e, input logic m);
    @(negedge clk);
    rst = r; en = e; mode_full = m;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    tick(1'b1, 1'b0, 1'b0);
    chk("R1 reset seed", state, 4'h8);
    chk("R7 no start in reset", {3'b0, start}, 4'h0);
    tick(1'b1, 1'b1, 1'b1);
    chk("R1 reset beats enable", state, 4'h8);
    chk("R7 start masked by reset", {3'b0, start}, 4'h0);
  endtask

  task automatic t_hold;
    tick(1'b1, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);
    chk("R2 hold at seed", state, 4'h8);
    chk("R7 no start when idle", {3'b0, start}, 4'h0);
    tick(1'b0, 1'b1, 1'b0);
    tick(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, 1'b0, 1'b0);
      chk("R2 hold mid lap", state, 4'h3);
    end
  endtask

  task automatic t_linear;
    logic [3:0] prev;
    tick(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0; en = 1'b1; mode_full = 1'b0;
    for (int i = 0; i < 30; i++) begin
      #1;
      chk("R4 linear order", state, LIN_SEQ[i % 15]);
      chk("R7 start strobe", {3'b0, start}, {3'b0, state == 4'h8});
      prev = state;
      @(posedge clk);
      #1;
      chk("R3 linear step", state, model(prev, 1'b0));
      @(negedge clk);
    end
  endtask

  task automatic t_full;
    logic [15:0] seen;
    tick(1'b1, 1'b0, 1'b1);
    seen = '0;
    seen[state] = 1'b1;
    tick(1'b0, 1'b1, 1'b1);
    chk("R5 1000 to 0000", state, 4'h0);
    seen[state] = 1'b1;
    tick(1'b0, 1'b1, 1'b1);
    chk("R5 0000 to 0001", state, 4'h1);
    seen[state] = 1'b1;
    for (int i = 0; i < 14; i++) begin
      logic [3:0] p;
      p = state;
      tick(1'b0, 1'b1, 1'b1);
      chk("R5 full step", state, model(p, 1'b1));
      seen[state] = 1'b1;
    end
    chk("R5 lap closes at seed", state, 4'h8);
    n_vec++;
    if (seen !== 16'hFFFF) begin
      n_bad++;
      $display("FAIL R5 coverage: got %h expected ffff", seen);
    end
  endtask

  task automatic t_unlock;
    tick(1'b1, 1'b0, 1'b1);
    tick(1'b0, 1'b1, 1'b1);
    chk("R5 reach zero", state, 4'h0);
    tick(1'b0, 1'b1, 1'b0);
    chk("R6 zero reloads seed", state, 4'h8);
  endtask

  task automatic t_switch_at_seed;
    tick(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0; en = 1'b1; mode_full = 1'b1;
    #1;
    chk("R7 start with switch", {3'b0, start}, 4'h1);
    @(posedge clk);
    #1;
    chk("R8 switch to full at seed", state, 4'h0);
    tick(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 14; i++) tick(1'b0, 1'b1, 1'b1);
    chk("R8 back at seed", state, 4'h8);
    tick(1'b0, 1'b1, 1'b0);
    chk("R8 switch to linear at seed", state, 4'h1);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_linear();
    t_full();
    t_unlock();
    t_switch_at_seed();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule